// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Engine

This block is the write side of a small serial EEPROM that sits on a two-wire bus as a slave. It oversamples SCL and SDA with a fast system clock and finds start and stop conditions on the synchronized lines. It shifts in bytes MSB first and checks the first byte against the fixed device-type nibble, the three strap inputs and a write direction bit. It then takes a word address and stages the data bytes that follow into an eight-entry page buffer. The slave acknowledges each byte by pulling SDA low during the ninth clock.

A stop condition that ends a transaction carrying at least one complete data byte starts a self-timed programming window of a parameterized number of clock cycles. For that whole window the slave is deaf to the bus. When the window closes, the staged bytes are written into the storage array, which has 2^ADDR_W bytes. Only the low three address bits advance between data bytes, so a long burst wraps inside its own eight-byte page, and a later byte replaces an earlier one that landed on the same location. A combinational peek port exposes the array contents.

Top module: `ee_write_slave`

## Requirements
- R1: After reset sda_pull and busy are 0, and every array location reads 0 on the peek port.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both are detected on the synchronized lines. SDA changes while SCL is low are data only.
- R3: The device byte is acknowledged only when its bits [7:4] are 4'b1010, bits [3:1] equal strap and bit [0] (R/W) is 0. Any other value gets no acknowledge, and no byte after it is acknowledged until the next start.
- R4: After a matching device byte, the word address byte and every data byte are acknowledged in their ninth clock.
- R5: The first data byte goes to the word address. Each following byte goes to the next address in which only bits [2:0] advance, modulo 8, while bits [7:3] stay fixed.
- R6: When one transaction writes the same page location twice because of the wrap, the array ends up holding the later byte.
- R7: A stop that follows at least one complete data byte raises busy for exactly TWR_CYCLES clock cycles. The array keeps its old contents while busy is high and holds the received bytes once busy falls.
- R8: While busy is high, the slave acknowledges nothing, including its own device address, and starts and stops on the bus have no effect.
- R9: A start or stop that arrives before any data byte is complete commits nothing and does not raise busy. A repeated start discards the bytes staged so far.
- R10: peek_data shows the array byte at peek_addr with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap | input | 3 | Address strap bits compared with device byte bits [3:1] |
| peek_addr | input | ADDR_W | Array location to observe |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| busy | output | 1 | High during the programming window |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
The checks assume a well-formed master. SDA moves only while SCL is low, except for start and stop. Every SCL level is held for several system clocks, so the synchronized copies never skip an edge. The master never drives a start or stop while the slave is pulling SDA low. The bench drives its master from tasks that hold each line for eight clocks per phase and release SDA during every acknowledge slot. It forms the wired bus level as the AND of the master's drive and the inverse of sda_pull. Under these conditions an acknowledge changes only on a detected SCL fall, and a programming window can only start from a stop.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int PAGE_W = 3;
    localparam int PAGE_N = 1 << PAGE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_DATA,
        ST_SKIP,
        ST_PROG
    } wr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_CODE) && (b[3:1] == strap) && !b[0];
    endfunction

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync
    import ee_wr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[LAST];
            sda_d  <= sda_ff[LAST];
        end
    end

    assign scl_s = scl_ff[LAST];
    assign sda_s = sda_ff[LAST];

    always_comb begin
        evt.start    = scl_d & scl_s & sda_d & ~sda_s;
        evt.stop     = scl_d & scl_s & ~sda_d & sda_s;
        evt.scl_rise = ~scl_d & scl_s;
        evt.scl_fall = scl_d & ~scl_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf
    import ee_wr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          we,
    input  logic [PAGE_W-1:0]             off,
    input  logic [7:0]                    wdata,
    output logic [PAGE_N-1:0][7:0]        slot_data,
    output logic [PAGE_N-1:0]             slot_vld
);
    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                slot_vld[g]  <= 1'b0;
                slot_data[g] <= '0;
            end else if (we && off == PAGE_W'(g)) begin
                slot_vld[g]  <= 1'b1;
                slot_data[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ee_store.sv
module ee_store
    import ee_wr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commit,
    input  logic [ADDR_W-PAGE_W-1:0] row,
    input  logic [PAGE_N-1:0][7:0] slot_data,
    input  logic [PAGE_N-1:0]      slot_vld,
    input  logic [ADDR_W-1:0]      peek_addr,
    output logic [7:0]             peek_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (slot_vld[i]) mem[{row, PAGE_W'(i)}] <= slot_data[i];
            end
        end
    end

    assign peek_data = mem[peek_addr];
endmodule

// File: rtl/ee_write_slave.sv
module ee_write_slave
    import ee_wr_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int TWR_CYCLES  = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic              sda_pull,
    output logic              busy,
    output logic [7:0]        peek_data
);
    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(TWR_CYCLES + 1);

    bus_evt_t             evt;
    wr_state_e            st, nxt_st;
    logic [3:0]           bit_cnt;
    logic [7:0]           shreg;
    logic [ADDR_W-1:0]    word_addr;
    logic [CNT_W-1:0]     prog_cnt;
    logic [PAGE_N-1:0][7:0] slot_data;
    logic [PAGE_N-1:0]    slot_vld;
    logic                 in_xfer, byte_end, ack_end;
    logic                 buf_we, buf_clr, commit, stop_commit;

    ee_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    assign in_xfer     = (st == ST_DEV) || (st == ST_WADDR) || (st == ST_DATA);
    assign byte_end    = in_xfer && evt.scl_fall && bit_cnt == 4'd8;
    assign ack_end     = in_xfer && evt.scl_fall && bit_cnt == 4'd9;
    assign stop_commit = evt.stop && st == ST_DATA && |slot_vld;
    assign commit      = (st == ST_PROG) && prog_cnt == '0;
    assign buf_we      = byte_end && st == ST_DATA;
    assign buf_clr     = commit || (st != ST_PROG && (evt.start || (evt.stop && !stop_commit)));
    assign busy        = (st == ST_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            nxt_st    <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_addr <= '0;
            prog_cnt  <= '0;
            sda_pull  <= 1'b0;
        end else if (st == ST_PROG) begin
            sda_pull <= 1'b0;
            if (prog_cnt == '0) st <= ST_IDLE;
            else prog_cnt <= prog_cnt - 1'b1;
        end else if (evt.start) begin
            st       <= ST_DEV;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            if (stop_commit) begin
                st       <= ST_PROG;
                prog_cnt <= CNT_W'(TWR_CYCLES - 1);
            end else begin
                st <= ST_IDLE;
            end
        end else if (in_xfer) begin
            if (evt.scl_rise && bit_cnt < 4'd8) begin
                shreg   <= {shreg[6:0], evt.sda};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
                bit_cnt <= 4'd9;
                unique case (st)
                    ST_DEV: begin
                        sda_pull <= dev_match(shreg, strap);
                        nxt_st   <= dev_match(shreg, strap) ? ST_WADDR : ST_SKIP;
                    end
                    ST_WADDR: begin
                        sda_pull  <= 1'b1;
                        word_addr <= shreg[ADDR_W-1:0];
                        nxt_st    <= ST_DATA;
                    end
                    default: begin
                        sda_pull  <= 1'b1;
                        word_addr <= {word_addr[ADDR_W-1:PAGE_W],
                                      word_addr[PAGE_W-1:0] + 1'b1};
                        nxt_st    <= ST_DATA;
                    end
                endcase
            end else if (ack_end) begin
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
                st       <= nxt_st;
            end
        end
    end

    ee_page_buf u_buf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
        .off(word_addr[PAGE_W-1:0]), .wdata(shreg),
        .slot_data(slot_data), .slot_vld(slot_vld)
    );

    ee_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .commit(commit),
        .row(word_addr[ADDR_W-1:PAGE_W]),
        .slot_data(slot_data), .slot_vld(slot_vld),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    logic [ROW_W-1:0] unused_row_chk;
    assign unused_row_chk = word_addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/ee_write_slave_chk.sv
module ee_write_slave_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              sda_pull,
    input logic              scl_fall,
    input logic              stop_det,
    input logic [ADDR_W-1:0] peek_addr,
    input logic [7:0]        peek_data
);
    // R8
    busy_mute_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull);

    // R7
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    // R4
    ack_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> $past(scl_fall));

    // R7
    store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && $stable(peek_addr)) |-> $stable(peek_data));
endmodule

bind ee_write_slave ee_write_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .sda_pull(sda_pull),
    .scl_fall(evt.scl_fall), .stop_det(evt.stop),
    .peek_addr(peek_addr), .peek_data(peek_data)
);

// File: tb/ee_write_slave_test.sv
module ee_write_slave_test;
    localparam int TWR = 600;
    localparam int H   = 8;
    localparam logic [7:0] MY_DEV = 8'hAA;   // 1010, strap 101, write

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [7:0] peek_addr = '0;
    logic sda_pull, busy;
    logic [7:0] peek_data;
    wire  sda_line = m_sda & ~sda_pull;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0] mdl [256];

    always #5 clk = ~clk;

    ee_write_slave #(.ADDR_W(8), .TWR_CYCLES(TWR)) uut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .strap(3'b101), .peek_addr(peek_addr),
        .sda_pull(sda_pull), .busy(busy), .peek_data(peek_data)
    );

    // {device byte, word address, byte count, data seed}
    localparam logic [31:0] VECS [0:6] = '{
        32'hAA_10_01_11, 32'hAA_3C_06_20, 32'hAA_80_08_31, 32'hAA_45_0A_52,
        32'hA8_22_02_77, 32'hAB_22_02_66, 32'hAA_FD_04_C3
    };

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(H);
        end
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H / 2);
        @(negedge clk) ack = sda_pull;
        tick(H / 2); m_scl = 1'b0; tick(H);
    endtask

    task automatic wait_prog_done();
        int w = 0;
        while (!busy && w < 40) begin tick(1); w++; end
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic mem_cmp(string tag);
        int bad = 0, first = -1;
        logic [7:0] got = '0;
        for (int a = 0; a < 256; a++) begin
            peek_addr = 8'(a); #1;
            if (peek_data !== mdl[a]) begin
                if (first < 0) begin first = a; got = peek_data; end
                bad++;
            end
        end
        check(bad == 0, $sformatf("%s array mismatch at %0h", tag, first),
              got, (first < 0) ? 0 : mdl[first]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        int n;
        for (int a = 0; a < 256; a++) mdl[a] = '0;
        tick(5); rst = 1'b0; tick(3);

        // R1 reset state
        check(sda_pull == 1'b0, "R1 sda_pull", sda_pull, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        mem_cmp("R1 R10");

        // table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            logic [7:0] dev, wa, cnt, seed;
            logic match;
            {dev, wa, cnt, seed} = VECS[v];
            match = (dev == MY_DEV);
            bus_start();
            send_byte(dev, ack);
            check(ack == match, $sformatf("R3 dev ack v%0d", v), ack, match);
            send_byte(wa, ack);
            check(ack == match, $sformatf("R3 R4 waddr ack v%0d", v), ack, match);
            for (int i = 0; i < cnt; i++) begin
                logic [7:0] d = seed + 8'(i * 8'h13);
                send_byte(d, ack);
                check(ack == match, $sformatf("R4 data ack v%0d", v), ack, match);
                if (match) mdl[{wa[7:3], 3'(wa[2:0] + 3'(i))}] = d;
            end
            bus_stop();
            if (match) wait_prog_done();
            else begin
                tick(4);
                check(busy == 1'b0, $sformatf("R3 no busy v%0d", v), busy, 0);
            end
            mem_cmp($sformatf("R5 R6 R7 R10 v%0d", v));
        end

        // R7 exact window length
        bus_start(); send_byte(MY_DEV, ack); send_byte(8'h50, ack); send_byte(8'h9E, ack);
        m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b1;
        n = 0;
        while (!busy && n < 40) begin @(negedge clk); n++; end
        n = 0;
        while (busy && n < TWR + 100) begin n++; @(negedge clk); end
        check(n == TWR, "R7 busy length", n, TWR);
        mdl[8'h50] = 8'h9E;
        tick(2);
        mem_cmp("R7 after window");

        // R8 deaf while busy, R7 commit only at end
        bus_start(); send_byte(MY_DEV, ack); send_byte(8'h60, ack); send_byte(8'h5A, ack);
        bus_stop();
        bus_start(); send_byte(MY_DEV, ack);
        check(ack == 1'b0, "R8 no ack while busy", ack, 0);
        check(busy == 1'b1, "R8 busy held", busy, 1);
        peek_addr = 8'h60; #1;
        check(peek_data == 8'h00, "R7 old value during busy", peek_data, 0);
        bus_stop();
        while (busy) tick(1);
        tick(2);
        peek_addr = 8'h60; #1;
        check(peek_data == 8'h5A, "R7 value after busy", peek_data, 8'h5A);
        mdl[8'h60] = 8'h5A;
        bus_start(); send_byte(MY_DEV, ack);
        check(ack == 1'b1, "R8 ack restored after busy", ack, 1);
        bus_stop(); tick(4);

        // R2 R9 stop inside a partial data byte
        bus_start(); send_byte(MY_DEV, ack); send_byte(8'h70, ack);
        send_bits(8'hF0, 4);
        bus_stop(); tick(4);
        check(busy == 1'b0, "R2 R9 partial byte no busy", busy, 0);
        mem_cmp("R9 partial byte");

        // R9 repeated start discards staged byte
        bus_start(); send_byte(MY_DEV, ack); send_byte(8'h74, ack); send_byte(8'h11, ack);
        bus_start(); send_byte(MY_DEV, ack);
        check(ack == 1'b1, "R2 repeated start ack", ack, 1);
        send_byte(8'h78, ack);
        bus_stop(); tick(4);
        check(busy == 1'b0, "R9 repeated start no busy", busy, 0);
        mem_cmp("R9 repeated start");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule